// File: doc/BRIEF.md
# Network Adapter Host I/O Glue

This block sits between a host I/O bus and a network controller on an adapter card. It answers a 32-port I/O window and holds three control registers. These registers hold the controller reset, the line-speed select, the cable-type select, the interrupt enable and the selects that steer a shared eight-port slot. Depending on those selects, the slot shows either the controller's sixteen host-interface registers, in two pages of eight, or a read-only identity ROM, also in two pages of eight. The ROM holds a maker code, a card type, a revision, three configuration bytes and a six-byte station address.

The controller's interrupt request is level-sensitive and is caught in a pending latch. Software sees the latch as a read-only flag. It acknowledges the latch by writing the interrupt enable to 0 and then back to 1. If the request is still high when the enable returns, the latch sets again, so a second request is not lost. In this project the controller is represented by a plain register-file stub that is cleared while the controller is held in reset.

Top module: `adapter_host_glue`

## Requirements
- R1: After reset, offsets 0x00, 0x01 and 0x07 read 0x00, ctrl_reset_n is 0, host_irq is 0, speed_16 is 0 and cable_utp is 0.
- R2: Offset 0x00 (control A) reads back bits 7..1 as last written, offset 0x01 (control B) reads back all bits as last written, and offset 0x07 (control C) reads back all bits as last written.
- R3: Offsets 0x02 to 0x06 and 0x10 to 0x1F read 0x00, and writes to them have no effect.
- R4: With control A bit 2 = 0 and bit 3 = 0, offsets 0x08 to 0x0F show ROM page zero: 0x4D, the card type, the revision, the three configuration bytes (most significant first), then 0x00 and 0x00.
- R5: With control A bit 2 = 0 and bit 3 = 1, the slot shows ROM page one: 0x00, the six station-address bytes (most significant first), then 0x00. Writes to the slot while the ROM is mapped change nothing.
- R6: With control A bit 2 = 1, slot offset 0x08+k reads and writes controller register {control B bit 3, k}, so bit 3 = 1 reaches registers 8 to 15.
- R7: ctrl_reset_n follows control B bit 0. While it is 0, every controller register reads 0x00 and writes to it are dropped.
- R8: speed_16 follows control B bit 2 (1 = 16 Mb/s), and cable_utp follows control C bit 0 (1 = UTP).
- R9: With control B bit 1 (interrupt enable) = 1, a high ctrl_irq_req sets the pending latch at the next clock edge. The latch stays set after the request falls, and it shows as control A bit 0.
- R10: host_irq is high exactly when the latch is set and the interrupt enable is 1.
- R11: Clearing the interrupt enable clears the latch one clock after the write. Restoring the enable while the request is still high sets the latch again one clock after the write.
- R12: While the interrupt enable is 0, ctrl_irq_req does not set the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Port offset within the I/O window |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the offset on addr |
| ctrl_irq_req | input | 1 | Level interrupt request from the controller |
| host_irq | output | 1 | Interrupt to the host |
| ctrl_reset_n | output | 1 | Controller reset, active low |
| speed_16 | output | 1 | Line-speed select, 1 = 16 Mb/s |
| cable_utp | output | 1 | Cable select, 1 = UTP, 0 = STP |

## Verification
The hardest case to reach is a request that is still high when software acknowledges the interrupt. To show that the request is not lost, the stimulus keeps ctrl_irq_req asserted across an enable-low write. It checks that the flag drops one cycle later, and then checks that it returns one cycle after the enable is written back. The second controller register page is reached only when three settings line up at once: reset released, the slot switched away from the ROM, and the page bit set. The stimulus writes a distinct value to the same slot offset in each page and reads both back, to show that the pages do not alias.

// File: rtl/adapter_glue_pkg.sv
package adapter_glue_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int SLOT_W  = 3;

    localparam logic [ADDR_W-1:0] OFS_CTL_A = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTL_B = 5'h01;
    localparam logic [ADDR_W-1:0] OFS_CTL_C = 5'h07;
    localparam logic [1:0]        SLOT_SEL  = 2'b01;

    // control A bit positions
    localparam int A_PEND   = 0;
    localparam int A_MAPSIF = 2;
    localparam int A_RPAGE  = 3;
    // control B bit positions
    localparam int B_RUN    = 0;
    localparam int B_IEN    = 1;
    localparam int B_SPEED  = 2;
    localparam int B_CPAGE  = 3;
    // control C bit positions
    localparam int C_UTP    = 0;

    typedef struct packed {
        logic [DATA_W-1:0] ctl_a;
        logic [DATA_W-1:0] ctl_b;
        logic [DATA_W-1:0] ctl_c;
    } ctl_regs_t;

    typedef struct packed {
        logic pend;
    } irq_state_t;
endpackage

// File: rtl/glue_id_rom.sv
module glue_id_rom #(
    parameter int          DATA_W    = 8,
    parameter int          IDX_W     = 3,
    parameter logic [7:0]  MFR_CODE  = 8'h4D,
    parameter logic [7:0]  CARD_TYPE = 8'h08,
    parameter logic [7:0]  CARD_REV  = 8'h02,
    parameter logic [23:0] CFG_BYTES = 24'h00_00_00,
    parameter logic [47:0] STATION   = 48'h0
) (
    input  logic              page,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] data
);
    localparam int DEPTH   = 2 ** IDX_W;
    localparam int N_CFG   = 3;
    localparam int N_ADDR  = 6;

    logic [DATA_W-1:0] pg0 [DEPTH];
    logic [DATA_W-1:0] pg1 [DEPTH];

    assign pg0[0] = MFR_CODE;
    assign pg0[1] = CARD_TYPE;
    assign pg0[2] = CARD_REV;
    assign pg1[0] = '0;

    for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
        assign pg0[3+g] = CFG_BYTES[23-8*g -: 8];
    end
    for (genvar g = 3 + N_CFG; g < DEPTH; g++) begin : g_pad0
        assign pg0[g] = '0;
    end
    for (genvar g = 0; g < N_ADDR; g++) begin : g_sta
        assign pg1[1+g] = STATION[47-8*g -: 8];
    end
    for (genvar g = 1 + N_ADDR; g < DEPTH; g++) begin : g_pad1
        assign pg1[g] = '0;
    end

    always_comb begin
        data = page ? pg1[idx] : pg0[idx];
    end
endmodule

// File: rtl/glue_ctrl_stub.sv
module glue_ctrl_stub #(
    parameter int DATA_W = 8,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs_d [NREG];
    logic [DATA_W-1:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = run ? regs_q[i] : '0;
        end
        if (run && we) begin
            regs_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign rdata = regs_q[idx];
endmodule

// File: rtl/glue_irq_latch.sv
module glue_irq_latch
    import adapter_glue_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic en,
    output logic pend,
    output logic irq_out
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.pend = 1'b0;
        end else if (req) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend    = st_q.pend;
    assign irq_out = st_q.pend & en;
endmodule

// File: rtl/adapter_host_glue.sv
module adapter_host_glue
    import adapter_glue_pkg::*;
#(
    parameter logic [7:0]  CARD_TYPE = 8'h08,
    parameter logic [7:0]  CARD_REV  = 8'h02,
    parameter logic [23:0] CFG_BYTES = 24'hA5_3C_81,
    parameter logic [47:0] STATION   = 48'h40_11_22_33_44_78
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ctrl_irq_req,
    output logic              host_irq,
    output logic              ctrl_reset_n,
    output logic              speed_16,
    output logic              cable_utp
);
    localparam int NREG  = 2 ** (SLOT_W + 1);
    localparam int IDX_W = SLOT_W + 1;

    ctl_regs_t ctl_d, ctl_q;

    logic              slot_hit;
    logic              map_sif;
    logic [IDX_W-1:0]  stub_idx;
    logic              stub_we;
    logic [DATA_W-1:0] stub_rdata;
    logic [DATA_W-1:0] rom_data;
    logic              irq_en;
    logic              irq_pending;

    assign slot_hit = (addr[ADDR_W-1:SLOT_W] == SLOT_SEL);
    assign map_sif  = ctl_q.ctl_a[A_MAPSIF];
    assign stub_idx = {ctl_q.ctl_b[B_CPAGE], addr[SLOT_W-1:0]};
    assign stub_we  = wr_en && slot_hit && map_sif;
    assign irq_en   = ctl_q.ctl_b[B_IEN];

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            unique case (addr)
                OFS_CTL_A: begin
                    ctl_d.ctl_a         = wdata;
                    ctl_d.ctl_a[A_PEND] = 1'b0;
                end
                OFS_CTL_B: ctl_d.ctl_b = wdata;
                OFS_CTL_C: ctl_d.ctl_c = wdata;
                default:   ctl_d = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    glue_id_rom #(
        .DATA_W    (DATA_W),
        .IDX_W     (SLOT_W),
        .MFR_CODE  (8'h4D),
        .CARD_TYPE (CARD_TYPE),
        .CARD_REV  (CARD_REV),
        .CFG_BYTES (CFG_BYTES),
        .STATION   (STATION)
    ) rom_i (
        .page (ctl_q.ctl_a[A_RPAGE]),
        .idx  (addr[SLOT_W-1:0]),
        .data (rom_data)
    );

    glue_ctrl_stub #(
        .DATA_W (DATA_W),
        .NREG   (NREG)
    ) stub_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_q.ctl_b[B_RUN]),
        .we    (stub_we),
        .idx   (stub_idx),
        .wdata (wdata),
        .rdata (stub_rdata)
    );

    glue_irq_latch irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (ctrl_irq_req),
        .en      (irq_en),
        .pend    (irq_pending),
        .irq_out (host_irq)
    );

    always_comb begin
        rdata = '0;
        if (slot_hit) begin
            rdata = map_sif ? stub_rdata : rom_data;
        end else begin
            unique case (addr)
                OFS_CTL_A: rdata = {ctl_q.ctl_a[DATA_W-1:1], irq_pending};
                OFS_CTL_B: rdata = ctl_q.ctl_b;
                OFS_CTL_C: rdata = ctl_q.ctl_c;
                default:   rdata = '0;
            endcase
        end
    end

    assign ctrl_reset_n = ctl_q.ctl_b[B_RUN];
    assign speed_16     = ctl_q.ctl_b[B_SPEED];
    assign cable_utp    = ctl_q.ctl_c[C_UTP];
endmodule

// File: rtl/glue_chk.sv
module glue_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] addr,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic       ctrl_irq_req,
    input logic       host_irq,
    input logic       ctrl_reset_n,
    input logic       speed_16,
    input logic       irq_en,
    input logic       irq_pending
);
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (irq_en && irq_pending)); // R10
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && ctrl_irq_req) |=> irq_pending); // R9
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && irq_pending) |=> irq_pending); // R9
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq_pending); // R11
    AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !irq_pending) |=> !irq_pending); // R12
    AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_reset_n) |-> $past(wr_en && addr == 5'h01 && wdata[0])); // R7
    AST_SPEED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(speed_16)); // R8
endmodule

bind adapter_host_glue glue_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .wr_en        (wr_en),
    .wdata        (wdata),
    .ctrl_irq_req (ctrl_irq_req),
    .host_irq     (host_irq),
    .ctrl_reset_n (ctrl_reset_n),
    .speed_16     (speed_16),
    .irq_en       (irq_en),
    .irq_pending  (irq_pending)
);

// File: tb/adapter_host_glue_tb_top.sv
module adapter_host_glue_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ctrl_irq_req = 1'b0;
    logic       host_irq, ctrl_reset_n, speed_16, cable_utp;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adapter_host_glue #(
        .CARD_TYPE (8'h08),
        .CARD_REV  (8'h02),
        .CFG_BYTES (24'hA5_3C_81),
        .STATION   (48'h40_11_22_33_44_78)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en),
        .wdata (wdata), .rdata (rdata), .ctrl_irq_req (ctrl_irq_req),
        .host_irq (host_irq), .ctrl_reset_n (ctrl_reset_n),
        .speed_16 (speed_16), .cable_utp (cable_utp)
    );

    typedef struct packed {
        bit       wr;
        bit [4:0] a;
        bit [7:0] d;
        bit [7:0] e;
        bit [3:0] r;
    } vec_t;

    localparam int NVEC = 31;
    // tags per row: R4 page zero, R2 readback, R5 page one, R6 controller pages, R3 unused
    localparam vec_t VEC [NVEC] = '{
        '{0, 5'h08, 8'h00, 8'h4D, 4'd4},
        '{0, 5'h09, 8'h00, 8'h08, 4'd4},
        '{0, 5'h0A, 8'h00, 8'h02, 4'd4},
        '{0, 5'h0B, 8'h00, 8'hA5, 4'd4},
        '{0, 5'h0C, 8'h00, 8'h3C, 4'd4},
        '{0, 5'h0D, 8'h00, 8'h81, 4'd4},
        '{0, 5'h0E, 8'h00, 8'h00, 4'd4},
        '{1, 5'h00, 8'h08, 8'h00, 4'd2},
        '{0, 5'h00, 8'h00, 8'h08, 4'd2},
        '{0, 5'h08, 8'h00, 8'h00, 4'd5},
        '{0, 5'h09, 8'h00, 8'h40, 4'd5},
        '{0, 5'h0E, 8'h00, 8'h78, 4'd5},
        '{1, 5'h09, 8'hFF, 8'h00, 4'd5},
        '{0, 5'h09, 8'h00, 8'h40, 4'd5},
        '{1, 5'h01, 8'h01, 8'h00, 4'd6},
        '{1, 5'h00, 8'h04, 8'h00, 4'd6},
        '{0, 5'h00, 8'h00, 8'h04, 4'd2},
        '{1, 5'h0A, 8'h5A, 8'h00, 4'd6},
        '{0, 5'h0A, 8'h00, 8'h5A, 4'd6},
        '{1, 5'h01, 8'h09, 8'h00, 4'd6},
        '{0, 5'h0A, 8'h00, 8'h00, 4'd6},
        '{1, 5'h0A, 8'hC3, 8'h00, 4'd6},
        '{0, 5'h0A, 8'h00, 8'hC3, 4'd6},
        '{0, 5'h01, 8'h00, 8'h09, 4'd2},
        '{1, 5'h01, 8'h01, 8'h00, 4'd6},
        '{0, 5'h0A, 8'h00, 8'h5A, 4'd6},
        '{1, 5'h03, 8'h77, 8'h00, 4'd3},
        '{0, 5'h03, 8'h00, 8'h00, 4'd3},
        '{0, 5'h15, 8'h00, 8'h00, 4'd3},
        '{1, 5'h07, 8'h01, 8'h00, 4'd2},
        '{0, 5'h07, 8'h00, 8'h01, 4'd2}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(5'h00, v); check("R1 ctl_a", v, 8'h00);
        rd(5'h01, v); check("R1 ctl_b", v, 8'h00);
        rd(5'h07, v); check("R1 ctl_c", v, 8'h00);
        check("R1 outputs", {4'b0, host_irq, ctrl_reset_n, speed_16, cable_utp}, 8'h00);

        // R7: controller held in reset drops writes
        wr(5'h00, 8'h04);
        wr(5'h0B, 8'hEE);
        rd(5'h0B, v); check("R7 write in reset", v, 8'h00);
        wr(5'h01, 8'h01);
        check("R7 reset released", {7'b0, ctrl_reset_n}, 8'h01);
        rd(5'h0B, v); check("R7 after release", v, 8'h00);
        wr(5'h0B, 8'h3E);
        wr(5'h01, 8'h00);
        check("R7 reset asserted", {7'b0, ctrl_reset_n}, 8'h00);
        @(negedge clk);
        wr(5'h01, 8'h01);
        rd(5'h0B, v); check("R7 cleared by reset", v, 8'h00);
        wr(5'h01, 8'h00);
        wr(5'h00, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) begin
                wr(VEC[i].a, VEC[i].d);
            end else begin
                rd(VEC[i].a, v);
                check($sformatf("R%0d vec %0d", VEC[i].r, i), v, VEC[i].e);
            end
        end

        // R8: speed and cable outputs
        wr(5'h01, 8'h05);
        check("R8 speed 16", {7'b0, speed_16}, 8'h01);
        check("R8 cable utp", {7'b0, cable_utp}, 8'h01);
        wr(5'h07, 8'h00);
        wr(5'h01, 8'h01);
        check("R8 speed 4 stp", {6'b0, speed_16, cable_utp}, 8'h00);

        // R12: request ignored while enable is low
        ctrl_irq_req = 1'b1;
        repeat (2) @(negedge clk);
        rd(5'h00, v); check("R12 flag stays low", {7'b0, v[0]}, 8'h00);
        check("R12 no host irq", {7'b0, host_irq}, 8'h00);
        ctrl_irq_req = 1'b0;

        // R9 / R10: set, hold after request falls
        wr(5'h01, 8'h03);
        rd(5'h00, v); check("R9 idle", {7'b0, v[0]}, 8'h00);
        ctrl_irq_req = 1'b1;
        @(negedge clk);
        rd(5'h00, v); check("R9 flag set", {7'b0, v[0]}, 8'h01);
        check("R10 host irq", {7'b0, host_irq}, 8'h01);
        ctrl_irq_req = 1'b0;
        repeat (2) @(negedge clk);
        rd(5'h00, v); check("R9 flag held", {7'b0, v[0]}, 8'h01);

        // R11: acknowledge with request still pending
        ctrl_irq_req = 1'b1;
        wr(5'h01, 8'h01);
        check("R10 gated by enable", {7'b0, host_irq}, 8'h00);
        @(negedge clk);
        rd(5'h00, v); check("R11 cleared", {7'b0, v[0]}, 8'h00);
        wr(5'h01, 8'h03);
        rd(5'h00, v); check("R11 not yet", {7'b0, v[0]}, 8'h00);
        @(negedge clk);
        rd(5'h00, v); check("R11 re-set", {7'b0, v[0]}, 8'h01);
        check("R11 host irq again", {7'b0, host_irq}, 8'h01);
        ctrl_irq_req = 1'b0;
        wr(5'h01, 8'h01);
        @(negedge clk);
        rd(5'h00, v); check("R11 final clear", {7'b0, v[0]}, 8'h00);

        finish_run();
    end
endmodule